// File: doc/BRIEF.md
# Bus trace capture controller

This block records consecutive samples of a monitored data bus into an on-chip word memory. A sample is stored each time the sampling strobe fires while the external run qualifier is high. The write pointer advances by one after every stored sample. Configuration inputs choose two behaviours. The first resets the pointer to zero when a run starts. The second decides whether capture, on reaching the last word, wraps round and overwrites the oldest data or stops and keeps what is already recorded. A sticky overflow flag reports that the pointer has gone past the last word.

A second, word-addressed access path serves a serial scan chain. The chain presents a frame that holds an address and a data word, and asks for either a read or a write at that address. Reads return the stored word one cycle later through a registered port. When a trace sample and a scan write fall in the same cycle, the trace sample is stored, the scan write is discarded, and the discard is reported on a flag.

Top module: `trc_capture_top`

## Requirements
- R1: After synchronous reset, wr_addr is 0, and ovf, scan_rvalid and scan_drop are all low.
- R2: On a clock edge where run_active and smp_strobe are both high, run_start is low and capture is not halted, bus_in is written at wr_addr, and wr_addr is one higher after that edge.
- R3: When run_active is low, smp_strobe writes nothing and wr_addr keeps its value.
- R4: On a run_start edge with cfg_clear_on_start high, wr_addr becomes 0 and ovf and the halt are cleared. With cfg_clear_on_start low, run_start leaves the address and the flags unchanged. In either case, a strobe in the run_start cycle is not stored.
- R5: With cfg_wrap high, a write at the top address (all ones) moves wr_addr to 0, and later samples overwrite the memory from address 0 upward.
- R6: ovf goes high after the edge at which a trace write takes place at the top address, and it stays high through later writes.
- R7: ovf_clear high at an edge clears ovf. If a write at the top address takes place in the same cycle, ovf is set instead.
- R8: With cfg_wrap low, once a write at the top address has taken place, further trace strobes neither write memory nor move wr_addr (which stays 0). This lasts until a run_start with cfg_clear_on_start high.
- R9: scan_frame carries the address in bits [ADDR_W+DATA_W-1:DATA_W] and the data in bits [DATA_W-1:0]. scan_req with scan_wr high writes that data at that address.
- R10: scan_req with scan_wr low reads the frame's address. After that edge, scan_rvalid is high for that cycle and scan_rdata holds the stored word.
- R11: If a trace write and a scan write fall in the same cycle, the trace sample is stored, the scan word is discarded, and scan_drop is high for exactly the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_clear_on_start | input | 1 | Reset the pointer and flags at run start |
| cfg_wrap | input | 1 | 1: wrap and overwrite at the top address; 0: halt there |
| run_start | input | 1 | One-cycle start-of-run pulse |
| run_active | input | 1 | Run qualifier for trace capture |
| smp_strobe | input | 1 | Sampling write strobe |
| bus_in | input | DATA_W | Monitored bus value |
| ovf_clear | input | 1 | Clears the overflow flag |
| scan_req | input | 1 | Scan access request |
| scan_wr | input | 1 | 1: scan write, 0: scan read |
| scan_frame | input | ADDR_W+DATA_W | Address (upper) and data (lower) |
| scan_rdata | output | DATA_W | Word returned by the last scan read |
| scan_rvalid | output | 1 | scan_rdata was updated at the last edge |
| scan_drop | output | 1 | A scan write was discarded at the last edge |
| wr_addr | output | ADDR_W | Current trace write pointer |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with DATA_W at 16 and ADDR_W at 4, which gives a 16-word memory. At that size, a run can reach the top address and go past it in a handful of strobes. Wrap-around overwrite, the halt without wrap, overflow set colliding with its clear, and the pointer reaching the top a second time can therefore all be driven directly. Scan accesses at scattered addresses, including the top word, show that the frame fields split correctly at this smaller address width.

// File: rtl/trc_pkg.sv
package trc_pkg;
  typedef enum logic [0:0] {
    SRC_TRACE = 1'b0,
    SRC_SCAN  = 1'b1
  } wr_src_e;
endpackage

// File: rtl/trc_addr_ctl.sv
module trc_addr_ctl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_clear_on_start,
  input  logic              cfg_wrap,
  input  logic              run_start,
  input  logic              run_active,
  input  logic              smp_strobe,
  input  logic              ovf_clear,
  output logic              trace_we,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              ovf,
  output logic              halted
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic [ADDR_W-1:0] addr_q;
  logic              ovf_q;
  logic              halt_q;

  always_comb trace_we = run_active & smp_strobe & ~run_start & ~halt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ovf_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (ovf_clear) ovf_q <= 1'b0;
      if (run_start) begin
        if (cfg_clear_on_start) begin
          addr_q <= '0;
          ovf_q  <= 1'b0;
          halt_q <= 1'b0;
        end
      end else if (trace_we) begin
        addr_q <= addr_q + 1'b1;
        if (addr_q == TOP_ADDR) begin
          ovf_q <= 1'b1;
          if (!cfg_wrap) halt_q <= 1'b1;
        end
      end
    end
  end

  assign wr_addr = addr_q;
  assign ovf     = ovf_q;
  assign halted  = halt_q;
endmodule

// File: rtl/trc_wr_arb.sv
module trc_wr_arb
  import trc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trace_we,
  input  logic [ADDR_W-1:0] trace_addr,
  input  logic [DATA_W-1:0] trace_data,
  input  logic              scan_req,
  input  logic              scan_wr,
  input  logic [ADDR_W-1:0] scan_addr,
  input  logic [DATA_W-1:0] scan_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              scan_drop
);
  wr_src_e src;
  logic    scan_wreq;
  logic    drop_q;

  always_comb begin
    scan_wreq = scan_req & scan_wr;
    src       = trace_we ? SRC_TRACE : SRC_SCAN;
    mem_we    = trace_we | scan_wreq;
    if (src == SRC_TRACE) begin
      mem_waddr = trace_addr;
      mem_wdata = trace_data;
    end else begin
      mem_waddr = scan_addr;
      mem_wdata = scan_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drop_q <= 1'b0;
    else     drop_q <= trace_we & scan_wreq;
  end

  assign scan_drop = drop_q;
endmodule

// File: rtl/trc_mem.sv
module trc_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata_q <= store[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/trc_capture_top.sv
module trc_capture_top #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_clear_on_start,
  input  logic                     cfg_wrap,
  input  logic                     run_start,
  input  logic                     run_active,
  input  logic                     smp_strobe,
  input  logic [DATA_W-1:0]        bus_in,
  input  logic                     ovf_clear,
  input  logic                     scan_req,
  input  logic                     scan_wr,
  input  logic [ADDR_W+DATA_W-1:0] scan_frame,
  output logic [DATA_W-1:0]        scan_rdata,
  output logic                     scan_rvalid,
  output logic                     scan_drop,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic                     ovf
);
  localparam int FRAME_W = ADDR_W + DATA_W;

  logic [ADDR_W-1:0] scan_addr;
  logic [DATA_W-1:0] scan_data;
  logic              trace_we;
  logic              halted;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              scan_re;
  logic              rvalid_q;

  assign scan_addr = scan_frame[FRAME_W-1:DATA_W];
  assign scan_data = scan_frame[DATA_W-1:0];
  assign scan_re   = scan_req & ~scan_wr;

  trc_addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk                (clk),
    .rst                (rst),
    .cfg_clear_on_start (cfg_clear_on_start),
    .cfg_wrap           (cfg_wrap),
    .run_start          (run_start),
    .run_active         (run_active),
    .smp_strobe         (smp_strobe),
    .ovf_clear          (ovf_clear),
    .trace_we           (trace_we),
    .wr_addr            (wr_addr),
    .ovf                (ovf),
    .halted             (halted)
  );

  trc_wr_arb #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arb (
    .clk        (clk),
    .rst        (rst),
    .trace_we   (trace_we),
    .trace_addr (wr_addr),
    .trace_data (bus_in),
    .scan_req   (scan_req),
    .scan_wr    (scan_wr),
    .scan_addr  (scan_addr),
    .scan_data  (scan_data),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .scan_drop  (scan_drop)
  );

  trc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .re    (scan_re),
    .raddr (scan_addr),
    .rdata (scan_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) rvalid_q <= 1'b0;
    else     rvalid_q <= scan_re;
  end

  assign scan_rvalid = rvalid_q;
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_clear_on_start,
  input logic              run_start,
  input logic              run_active,
  input logic              ovf_clear,
  input logic              scan_req,
  input logic              scan_wr,
  input logic              scan_rvalid,
  input logic              scan_drop,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              ovf,
  input logic              trace_we,
  input logic              halted
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    trace_we |=> (wr_addr == $past(wr_addr) + 1'b1)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!run_active && !run_start) |=> $stable(wr_addr)); // R3
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (run_start && cfg_clear_on_start) |=> (wr_addr == '0) && !ovf && !halted); // R4
  AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
    (trace_we && (wr_addr == '1)) |=> ovf); // R6
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ovf_clear && !trace_we) |=> !ovf); // R7
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (halted && !run_start) |=> $stable(wr_addr) && halted); // R8
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (scan_req && !scan_wr) |=> scan_rvalid); // R10
  AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
    (scan_req && scan_wr && trace_we) |=> scan_drop); // R11
  AST_NO_DROP: assert property (@(posedge clk) disable iff (rst)
    !(scan_req && scan_wr) |=> !scan_drop); // R11
endmodule

bind trc_capture_top trc_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk                (clk),
  .rst                (rst),
  .cfg_clear_on_start (cfg_clear_on_start),
  .run_start          (run_start),
  .run_active         (run_active),
  .ovf_clear          (ovf_clear),
  .scan_req           (scan_req),
  .scan_wr            (scan_wr),
  .scan_rvalid        (scan_rvalid),
  .scan_drop          (scan_drop),
  .wr_addr            (wr_addr),
  .ovf                (ovf),
  .trace_we           (trace_we),
  .halted             (halted)
);

// File: tb/test_trc_capture_top.sv
module test_trc_capture_top;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int NV = 6;
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {4'h3, 16'h1234}, {4'h7, 16'h7A7A}, {4'h9, 16'h0F0F},
    {4'hC, 16'hBEEF}, {4'hE, 16'h8001}, {4'hF, 16'hFFFE}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_clear_on_start = 1'b0, cfg_wrap = 1'b0;
  logic run_start = 1'b0, run_active = 1'b0, smp_strobe = 1'b0;
  logic [DW-1:0] bus_in = '0;
  logic ovf_clear = 1'b0, scan_req = 1'b0, scan_wr = 1'b0;
  logic [AW+DW-1:0] scan_frame = '0;
  logic [DW-1:0] scan_rdata;
  logic scan_rvalid, scan_drop, ovf;
  logic [AW-1:0] wr_addr;
  int total = 0;
  int bad = 0;
  logic [DW-1:0] rd;

  always #4 clk = ~clk;

  trc_capture_top #(.DATA_W(DW), .ADDR_W(AW)) i_trc_capture_top (
    .clk(clk), .rst(rst), .cfg_clear_on_start(cfg_clear_on_start),
    .cfg_wrap(cfg_wrap), .run_start(run_start), .run_active(run_active),
    .smp_strobe(smp_strobe), .bus_in(bus_in), .ovf_clear(ovf_clear),
    .scan_req(scan_req), .scan_wr(scan_wr), .scan_frame(scan_frame),
    .scan_rdata(scan_rdata), .scan_rvalid(scan_rvalid), .scan_drop(scan_drop),
    .wr_addr(wr_addr), .ovf(ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic scan_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    scan_req = 1'b1; scan_wr = 1'b1; scan_frame = {a, d};
    step();
    scan_req = 1'b0; scan_wr = 1'b0;
  endtask

  task automatic scan_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    scan_req = 1'b1; scan_wr = 1'b0; scan_frame = {a, 16'h0000};
    step();
    chk("R10 rvalid", 32'(scan_rvalid), 32'd1);
    d = scan_rdata;
    scan_req = 1'b0;
  endtask

  task automatic trace_wr(input logic [DW-1:0] d);
    run_active = 1'b1; smp_strobe = 1'b1; bus_in = d;
    step();
    smp_strobe = 1'b0;
  endtask

  task automatic start_run(input logic clr);
    cfg_clear_on_start = clr; run_start = 1'b1;
    step();
    run_start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 wr_addr", 32'(wr_addr), 0);
    chk("R1 ovf", 32'(ovf), 0);
    chk("R1 rvalid", 32'(scan_rvalid), 0);
    chk("R1 drop", 32'(scan_drop), 0);

    // R9 / R10 table of scan writes and read-backs
    for (int i = 0; i < NV; i++) scan_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    for (int i = 0; i < NV; i++) begin
      scan_read(VEC[i][AW+DW-1:DW], rd);
      chk("R9 readback", 32'(rd), 32'(VEC[i][DW-1:0]));
    end
    step();
    chk("R10 rvalid drops", 32'(scan_rvalid), 0);

    // R2 trace writes
    start_run(1'b1);
    chk("R4 start clear", 32'(wr_addr), 0);
    for (int i = 0; i < 3; i++) begin
      trace_wr(16'hA000 + 16'(i));
      chk("R2 addr step", 32'(wr_addr), 32'(i + 1));
    end
    for (int i = 0; i < 3; i++) begin
      scan_read(AW'(i), rd);
      chk("R2 stored", 32'(rd), 32'(16'hA000 + 16'(i)));
    end

    // R3 strobe without qualifier
    run_active = 1'b0; smp_strobe = 1'b1; bus_in = 16'hFFFF;
    step();
    smp_strobe = 1'b0;
    chk("R3 addr hold", 32'(wr_addr), 3);
    scan_read(4'h3, rd);
    chk("R3 mem untouched", 32'(rd), 32'h1234);

    // R11 collision
    run_active = 1'b1; smp_strobe = 1'b1; bus_in = 16'hC0DE;
    scan_req = 1'b1; scan_wr = 1'b1; scan_frame = {4'h7, 16'h5A5A};
    step();
    smp_strobe = 1'b0; scan_req = 1'b0; scan_wr = 1'b0;
    chk("R11 drop flag", 32'(scan_drop), 1);
    chk("R11 trace advanced", 32'(wr_addr), 4);
    step();
    chk("R11 drop one cycle", 32'(scan_drop), 0);
    scan_read(4'h7, rd);
    chk("R11 scan word discarded", 32'(rd), 32'h7A7A);
    scan_read(4'h3, rd);
    chk("R11 trace word kept", 32'(rd), 32'hC0DE);

    // R4 start without clear, strobe in start cycle
    scan_write(4'h4, 16'h4444);
    cfg_clear_on_start = 1'b0; run_start = 1'b1; smp_strobe = 1'b1; bus_in = 16'h5555;
    step();
    run_start = 1'b0; smp_strobe = 1'b0;
    chk("R4 no clear", 32'(wr_addr), 4);
    scan_read(4'h4, rd);
    chk("R4 start cycle not stored", 32'(rd), 32'h4444);

    // R5 / R6 wrap
    cfg_wrap = 1'b1;
    start_run(1'b1);
    for (int i = 0; i < 15; i++) trace_wr(16'h0100 + 16'(i));
    chk("R6 ovf low below top", 32'(ovf), 0);
    chk("R5 at top", 32'(wr_addr), 15);
    trace_wr(16'h010F);
    chk("R5 wrap addr", 32'(wr_addr), 0);
    chk("R6 ovf set", 32'(ovf), 1);
    trace_wr(16'h2000);
    chk("R6 ovf sticky", 32'(ovf), 1);
    scan_read(4'h0, rd);
    chk("R5 overwrite", 32'(rd), 32'h2000);
    scan_read(4'hF, rd);
    chk("R5 top word", 32'(rd), 32'h010F);

    // R7 clear, then set wins over clear
    ovf_clear = 1'b1;
    step();
    ovf_clear = 1'b0;
    chk("R7 clear", 32'(ovf), 0);
    for (int i = 0; i < 14; i++) trace_wr(16'h0200 + 16'(i));
    chk("R7 at top again", 32'(wr_addr), 15);
    ovf_clear = 1'b1;
    trace_wr(16'h02FF);
    ovf_clear = 1'b0;
    chk("R7 set wins", 32'(ovf), 1);

    // R8 halt without wrap
    cfg_wrap = 1'b0;
    start_run(1'b1);
    chk("R4 ovf cleared by start", 32'(ovf), 0);
    for (int i = 0; i < 16; i++) trace_wr(16'h0300 + 16'(i));
    chk("R8 ovf", 32'(ovf), 1);
    chk("R8 addr at zero", 32'(wr_addr), 0);
    trace_wr(16'hDEAD);
    chk("R8 addr halted", 32'(wr_addr), 0);
    scan_read(4'h0, rd);
    chk("R8 mem preserved", 32'(rd), 32'h0300);
    start_run(1'b0);
    trace_wr(16'hBAD0);
    chk("R8 still halted", 32'(wr_addr), 0);
    start_run(1'b1);
    trace_wr(16'h7777);
    chk("R8 resume", 32'(wr_addr), 1);
    scan_read(4'h0, rd);
    chk("R8 resume write", 32'(rd), 32'h7777);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule